// File: doc/BRIEF.md
# Readback CRC Trailer Generator

This block sits in a serial readback path. Every data bit offered on the input side is copied to the serial output one cycle later. A CRC-16 runs over each of those bits using the polynomial x^16 + x^12 + x^5 + 1. When the producer marks a bit as the final one, the block stops taking input. It then shifts the eleven upper bits of the remainder onto the same serial output, highest bit first, so the stream ends with a short checksum.

After the checksum, a one-cycle completion strobe fires and the CRC register returns to zero, ready for the next readback. The eleven-bit checksum is also held in a register. A host can compare it against the checksum of an earlier readback: the block compares the held value with a reference input and flags any difference, which shows that the read-back contents have changed.

Top module: `rbk_crc_trailer`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid and done are 0, in_ready is 1 and sig_q is 0.
- R2: A bit accepted on a cycle (in_valid and in_ready both high) appears on out_bit with out_valid high on the next cycle, with the same value.
- R3: The CRC register starts at zero and advances once per accepted bit, MSB first, with polynomial 0x1021: feedback = crc[15] xor bit, crc = (crc << 1) xor (feedback ? 0x1021 : 0). Cycles with in_valid low leave it and the output stream untouched.
- R4: Right after the final data bit leaves the output, the next 11 cycles carry out_valid high and the remainder bits 15 down to 5, in that order.
- R5: From the cycle after the final bit (in_last) is accepted until the cycle before done, in_ready is low, and in_valid during those cycles has no effect on the output stream.
- R6: done is high for exactly one cycle, the cycle after the last checksum bit, with out_valid low; in_ready is high again on that cycle.
- R7: By the done cycle, sig_q holds bits 15 down to 5 of the remainder for the readback just finished, and it stays unchanged until the next readback's checksum is sent.
- R8: mismatch is high exactly when sig_q differs from ref_sig, on the same cycle.
- R9: The CRC restarts from zero for each readback, so sending the same bits again gives the same sig_q.
- R10: A readback of a single bit with in_last set works; a single 1 bit gives sig_q = 11'h081.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bit | input | 1 | Readback data bit |
| in_valid | input | 1 | in_bit is present this cycle |
| in_last | input | 1 | This bit ends the readback |
| in_ready | output | 1 | Block accepts a bit this cycle |
| out_bit | output | 1 | Serial output: data bits, then checksum bits |
| out_valid | output | 1 | out_bit is present this cycle |
| done | output | 1 | One-cycle strobe after the checksum |
| ref_sig | input | 11 | Checksum from an earlier readback |
| sig_q | output | 11 | Checksum of the latest readback |
| mismatch | output | 1 | sig_q differs from ref_sig |

## Verification
The assertions assume that the producer treats in_ready as a qualifier: a bit offered while in_ready is low is simply not taken. They also assume in_last only means something on an accepted bit. The stimulus offers real bits only on cycles where in_ready is high. During the trailer window it drives in_valid, in_bit and in_last with junk on purpose, so that the ignore path is exercised. Idle gaps with random in_bit values appear between data bits, and ref_sig changes only between readbacks.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    localparam int unsigned        CRC_W_DEF    = 16;
    localparam logic [15:0]        CRC_POLY_DEF = 16'h1021;
    localparam int unsigned        SIG_W_DEF    = 11;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_SEND = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic data;
    } sbit_t;

    function automatic logic [CRC_W_DEF-1:0] trailer_field_mask(input int unsigned sig_w);
        logic [CRC_W_DEF-1:0] m;
        m = '0;
        for (int i = 0; i < CRC_W_DEF; i++) begin
            if (i >= int'(CRC_W_DEF - sig_w)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rbk_crc_engine.sv
module rbk_crc_engine #(
    parameter int unsigned   W    = rbk_pkg::CRC_W_DEF,
    parameter logic [W-1:0]  POLY = rbk_pkg::CRC_POLY_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         din,
    input  logic         clr,
    output logic [W-1:0] crc_q
);

    logic         fb;
    logic [W-1:0] crc_nxt;

    assign fb = crc_q[W-1] ^ din;

    for (genvar gi = 0; gi < W; gi++) begin : g_tap
        if (gi == 0) begin : g_lsb
            assign crc_nxt[gi] = fb & POLY[gi];
        end else begin : g_up
            assign crc_nxt[gi] = crc_q[gi-1] ^ (fb & POLY[gi]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= '0;
        end else if (adv) begin
            crc_q <= crc_nxt;
        end
    end

    // R3: no accepted bit, no clear -> remainder holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(crc_q));

    // R9: clearing returns the remainder to zero for the next readback
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_q == '0));

endmodule

// File: rtl/rbk_trailer_seq.sv
module rbk_trailer_seq #(
    parameter int unsigned SIG_W = rbk_pkg::SIG_W_DEF,
    localparam int unsigned CW   = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_last,
    output rbk_pkg::seq_state_e     state_q,
    output logic [CW-1:0]           idx_q,
    output logic                    ready,
    output logic                    done_q
);
    import rbk_pkg::*;

    localparam logic [CW-1:0] IDX_END = CW'(SIG_W - 1);

    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DATA: if (acc_last) state_d = ST_SEND;
            ST_SEND: if (idx_q == IDX_END) state_d = ST_FIN;
            ST_FIN:  state_d = ST_DATA;
            default: state_d = ST_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_FIN);
            if (state_q == ST_SEND) idx_q <= idx_q + 1'b1;
            else                    idx_q <= '0;
        end
    end

    assign ready = (state_q == ST_DATA);

    // R5: final bit taken -> input closes on the next cycle
    a_r5_ready_drop: assert property (@(posedge clk) disable iff (rst)
        acc_last |=> !ready);

    // R6: completion strobe lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R6: input reopens on the strobe cycle
    a_r6_done_ready: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ready);

endmodule

// File: rtl/rbk_out_stage.sv
module rbk_out_stage #(
    parameter int unsigned W     = rbk_pkg::CRC_W_DEF,
    parameter int unsigned SIG_W = rbk_pkg::SIG_W_DEF,
    localparam int unsigned CW   = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  rbk_pkg::seq_state_e state_q,
    input  logic                acc,
    input  logic                din,
    input  logic [W-1:0]        crc_q,
    input  logic [CW-1:0]       idx_q,
    output logic                out_bit,
    output logic                out_valid
);
    import rbk_pkg::*;

    sbit_t        out_q;
    sbit_t        out_d;
    logic [W-1:0] shifted;

    assign shifted = crc_q << idx_q;

    always_comb begin
        out_d = '0;
        if (state_q == ST_SEND) begin
            out_d.valid = 1'b1;
            out_d.data  = shifted[W-1];
        end else if (acc) begin
            out_d.valid = 1'b1;
            out_d.data  = din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_bit   = out_q.data;
    assign out_valid = out_q.valid;

    // R4: every trailer cycle puts a bit on the output
    a_r4_send_valid: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND) |=> out_valid);

endmodule

// File: rtl/rbk_crc_trailer.sv
module rbk_crc_trailer #(
    parameter int unsigned       CRC_W    = rbk_pkg::CRC_W_DEF,
    parameter logic [CRC_W-1:0]  CRC_POLY = rbk_pkg::CRC_POLY_DEF,
    parameter int unsigned       SIG_W    = rbk_pkg::SIG_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_bit,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_bit,
    output logic             out_valid,
    output logic             done,
    input  logic [SIG_W-1:0] ref_sig,
    output logic [SIG_W-1:0] sig_q,
    output logic             mismatch
);
    import rbk_pkg::*;

    localparam int unsigned CW = (SIG_W > 1) ? $clog2(SIG_W) : 1;

    logic             acc;
    logic             acc_last;
    logic [CRC_W-1:0] crc_q;
    seq_state_e       state_q;
    logic [CW-1:0]    idx_q;
    logic             ld_sig;

    assign acc      = in_valid && in_ready;
    assign acc_last = acc && in_last;

    rbk_crc_engine #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .adv   (acc),
        .din   (in_bit),
        .clr   (state_q == ST_FIN),
        .crc_q (crc_q)
    );

    rbk_trailer_seq #(.SIG_W(SIG_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .acc_last (acc_last),
        .state_q  (state_q),
        .idx_q    (idx_q),
        .ready    (in_ready),
        .done_q   (done)
    );

    rbk_out_stage #(.W(CRC_W), .SIG_W(SIG_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .state_q   (state_q),
        .acc       (acc),
        .din       (in_bit),
        .crc_q     (crc_q),
        .idx_q     (idx_q),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    assign ld_sig = (state_q == ST_SEND) && (idx_q == '0);

    always_ff @(posedge clk) begin
        if (rst)         sig_q <= '0;
        else if (ld_sig) sig_q <= crc_q[CRC_W-1 -: SIG_W];
    end

    assign mismatch = (sig_q != ref_sig);

    // R2: accepted bit shows on the output next cycle, same value
    a_r2_pass_valid: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);
    a_r2_pass_bit: assert property (@(posedge clk) disable iff (rst)
        acc |=> (out_bit == $past(in_bit)));

    // R6: strobe cycle carries no output bit
    a_r6_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R7: signature is held while data is being taken
    a_r7_sig_hold: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> $stable(sig_q));

endmodule

// File: tb/rbk_crc_trailer_bench.sv
`timescale 1ns/1ps
module rbk_crc_trailer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_bit = 1'b0, in_valid = 1'b0, in_last = 1'b0;
    logic        in_ready, out_bit, out_valid, done, mismatch;
    logic [10:0] ref_sig = '0;
    logic [10:0] sig_q;

    int checks = 0;
    int errors = 0;
    logic exp_q[$];

    always #2.5 clk = ~clk;

    rbk_crc_trailer u_rbk_crc_trailer (
        .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_bit(out_bit),
        .out_valid(out_valid), .done(done), .ref_sig(ref_sig),
        .sig_q(sig_q), .mismatch(mismatch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_step(input logic [15:0] c, input logic b);
        logic [15:0] s;
        s = {c[14:0], 1'b0};
        if (c[15] != b) s = s ^ 16'h1021;
        return s;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2/R5 unexpected output bit", int'(out_bit), 0);
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk(out_bit == e, "R2/R4 output bit", int'(out_bit), int'(e));
            end
        end
    end

    task automatic run_stream(input logic [127:0] pat, input int n, input bit gaps,
                              output logic [10:0] exp_sig);
        logic [15:0] c;
        c = '0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                in_bit   = $urandom_range(0, 1);
                in_last  = $urandom_range(0, 1);
                @(negedge clk);
            end
            chk(in_ready == 1'b1, "R5 ready during data", int'(in_ready), 1);
            in_valid = 1'b1;
            in_bit   = pat[i];
            in_last  = (i == n - 1);
            exp_q.push_back(pat[i]);
            c = model_step(c, pat[i]); // R3 model
            if (i == n - 1) begin
                for (int j = 0; j < 11; j++) exp_q.push_back(c[15-j]); // R4 order
            end
            @(negedge clk);
        end
        // trailer window: junk on the inputs must be ignored (R5)
        for (int k = 1; k <= 12; k++) begin
            chk(in_ready == 1'b0, "R5 ready low in trailer", int'(in_ready), 0);
            chk(done == 1'b0, "R6 no early done", int'(done), 0);
            in_valid = 1'b1;
            in_bit   = $urandom_range(0, 1);
            in_last  = $urandom_range(0, 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(done == 1'b1, "R6 done after trailer", int'(done), 1);
        chk(in_ready == 1'b1, "R6 ready on done", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R6 no output on done", int'(out_valid), 0);
        exp_sig = c[15:5];
        chk(sig_q == exp_sig, "R7 signature", int'(sig_q), int'(exp_sig));
        chk(exp_q.size() == 0, "R4 all trailer bits seen", exp_q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
        chk(sig_q == exp_sig, "R7 signature held", int'(sig_q), int'(exp_sig));
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] s_a, s_b, s_c;
        logic [127:0] lfsr_pat;
        logic [31:0] l;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && done == 1'b0, "R1 outputs idle in reset", int'({out_valid, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        chk(sig_q == 11'd0, "R1 signature zero", int'(sig_q), 0);
        chk(mismatch == 1'b0, "R8 equal at reset", int'(mismatch), 0);

        // R10: single bit readback
        run_stream(128'h1, 1, 1'b0, s_a);
        chk(sig_q == 11'h081, "R10 single one bit", int'(sig_q), 11'h081);

        // all zeros: remainder stays zero (R3)
        run_stream(128'h0, 20, 1'b1, s_a);
        chk(sig_q == 11'h000, "R3 zero stream", int'(sig_q), 0);

        // all ones with gaps
        run_stream({112'h0, 16'hFFFF}, 16, 1'b1, s_a);

        // pseudo-random stream, then repeat (R9) and compare (R8)
        l = 32'hACE1_2468;
        for (int i = 0; i < 128; i++) begin
            lfsr_pat[i] = l[0];
            l = {l[0] ^ l[2] ^ l[6] ^ l[7], l[31:1]};
        end
        run_stream(lfsr_pat, 90, 1'b1, s_b);
        ref_sig = s_b;
        #1;
        chk(mismatch == 1'b0, "R8 equal reference", int'(mismatch), 0);
        run_stream(lfsr_pat, 90, 1'b0, s_c);
        chk(sig_q == s_b, "R9 same bits same signature", int'(sig_q), int'(s_b));
        chk(mismatch == 1'b0, "R8 repeat matches", int'(mismatch), 0);

        // changed content -> flagged
        lfsr_pat[40] = ~lfsr_pat[40];
        run_stream(lfsr_pat, 90, 1'b1, s_c);
        chk(mismatch == (s_c != s_b), "R8 changed readback", int'(mismatch), int'(s_c != s_b));
        ref_sig = sig_q ^ 11'h400;
        #1;
        chk(mismatch == 1'b1, "R8 differing reference", int'(mismatch), 1);

        // R2: an alternating pattern at full rate
        run_stream({64'h0, 64'h5555_AAAA_3C3C_0F0F}, 64, 1'b0, s_a);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule